// File: doc/BRIEF.md
# Priority-Match Content-Addressable Memory with Next-Free Tracking

This block holds a small set of 64-bit words, each guarded by a valid bit, and searches every valid word against a key in one cycle. When more than one entry matches, the entry with the lowest index wins and counts as the highest-priority match. The block also keeps track of the lowest-index empty entry, called the next-free slot. A new word can be stored there without the caller supplying an address.

Each operation is requested by raising a cycle strobe with an operation code on the same clock edge. The block then updates a registered active-address value. This value reports the address that the last operation produced: the match index after a compare, the next-free index after a write-at-next-free, or the supplied address after a direct access. It reads all ones when a compare misses or when a write-at-next-free finds the array full. The match index held from the last compare can be reused to read or rewrite that entry. An active-low output enable gates the active-address bus.

Top module: `pmcam_top`

## Requirements
- R1: After synchronous reset every entry is empty, the active address is zero, rdata is zero, and match_flag, multi_flag and full are low.
- R2: A cycle with op code 1 (compare) loads the lowest valid index whose stored word equals din into the active address, zero-extended, and sets match_flag. multi_flag is set when two or more valid entries match.
- R3: A compare that finds no valid equal entry sets the active address to all ones and clears match_flag and multi_flag. Empty entries never match.
- R4: Op code 4 (write at next free) stores din in the lowest-index empty entry, marks it valid, and loads that index into the active address.
- R5: When every entry is valid, full is high. Op code 4 then writes nothing and sets the active address to all ones.
- R6: Op code 2 (write at address) stores din at addr and marks it valid. Op code 3 (read at address) puts the word at addr on rdata. Op code 7 (invalidate) clears the valid bit at addr. All three load addr into the active address.
- R7: Op code 5 (read at match) and op code 6 (write at match) act on the index held from the last compare and load it into the active address. If that compare missed, nothing is written, rdata keeps its value, and the active address becomes all ones.
- R8: Without a cycle strobe, or with op code 0, the active address and rdata keep their values.
- R9: While aa_oe_n is high, aa_bus is zero and aa_drive is low. While aa_oe_n is low, aa_bus shows the active address and aa_drive is high.
- R10: match_flag and multi_flag change only on a compare cycle or on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_go | input | 1 | Operation strobe, sampled at the rising edge |
| op | input | 3 | Operation code |
| addr | input | $clog2(DEPTH) | Direct entry address |
| din | input | WIDTH | Write data and compare key |
| aa_oe_n | input | 1 | Active-low enable for aa_bus |
| aa_bus | output | AA_W | Active-address output |
| aa_drive | output | 1 | High while aa_bus is enabled |
| rdata | output | WIDTH | Registered read data |
| match_flag | output | 1 | Last compare found a match |
| multi_flag | output | 1 | Last compare found several matches |
| full | output | 1 | All entries valid |

## Verification
The bench builds the block with DEPTH of 8, WIDTH of 64 and AA_W of 13. With only eight entries, the array fills within a few writes, so the full-array miss of write-at-next-free can be reached. The 13-bit field also shows the zero-extension of a 3-bit index against an all-ones miss code. Duplicate stored words exercise lowest-index priority and the multiple-match flag. An invalidate followed by a write-at-next-free shows that a freed low slot is reused first.

// File: rtl/pmcam_pkg.sv
// Shared operation codes for the priority-match CAM.
// Assumes a 3-bit operation field at the top-level port.
package pmcam_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_CMP    = 3'd1,
        OP_WR_AT  = 3'd2,
        OP_RD_AT  = 3'd3,
        OP_WR_NF  = 3'd4,
        OP_RD_HPM = 3'd5,
        OP_WR_HPM = 3'd6,
        OP_INVAL  = 3'd7
    } cam_op_e;
endpackage

// File: rtl/pmcam_first_set.sv
// Lowest-index set-bit finder.
// Reports whether any bit of vec is set and the index of the lowest one.
// Assumes IW is wide enough to hold N-1.
module pmcam_first_set #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/pmcam_store.sv
// Entry storage with a per-entry valid bit and a parallel equality search.
// One write or one clear per cycle. The read port is combinational.
// Assumes the caller never asserts wr_en and clr_en together.
module pmcam_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 64,
    parameter int IW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             clr_en,
    input  logic [IW-1:0]    clr_idx,
    input  logic [WIDTH-1:0] key,
    input  logic [IW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_word,
    output logic [DEPTH-1:0] hit_vec,
    output logic [DEPTH-1:0] valid_vec
);
    logic [WIDTH-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Update one entry's word and valid bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g]       <= '0;
                valid_vec[g] <= 1'b0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                mem[g]       <= wr_data;
                valid_vec[g] <= 1'b1;
            end else if (clr_en && clr_idx == IW'(g)) begin
                valid_vec[g] <= 1'b0;
            end
        end

        // Compare this entry against the key. Empty entries never hit.
        assign hit_vec[g] = valid_vec[g] && (mem[g] == key);
    end

    // Select the addressed word for reading.
    assign rd_word = mem[rd_idx];
endmodule

// File: rtl/pmcam_top.sv
// Priority-match CAM top level.
// Decodes one operation per strobed cycle. Keeps the match result of the
// last compare and registers an active address for every operation.
// Assumes DEPTH is a power of two, at least 2, and AA_W >= $clog2(DEPTH).
module pmcam_top #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 64,
    parameter int AA_W  = 13,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_go,
    input  logic [2:0]       op,
    input  logic [IW-1:0]    addr,
    input  logic [WIDTH-1:0] din,
    input  logic             aa_oe_n,
    output logic [AA_W-1:0]  aa_bus,
    output logic             aa_drive,
    output logic [WIDTH-1:0] rdata,
    output logic             match_flag,
    output logic             multi_flag,
    output logic             full
);
    import pmcam_pkg::*;

    localparam logic [AA_W-1:0] AA_MISS = '1;

    cam_op_e          op_e;
    logic             wr_en, clr_en;
    logic [IW-1:0]    wr_idx, rd_idx;
    logic [WIDTH-1:0] rd_word;
    logic [DEPTH-1:0] hit_vec, valid_vec;
    logic             cmp_found, nf_found, cmp_multi;
    logic [IW-1:0]    cmp_idx, nf_idx;
    logic             hit_q, multi_q;
    logic [IW-1:0]    hit_idx_q;
    logic [AA_W-1:0]  aa_q;
    logic [WIDTH-1:0] rdata_q;

    assign op_e = cam_op_e'(op);

    pmcam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IW(IW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (din),
        .clr_en   (clr_en),
        .clr_idx  (addr),
        .key      (din),
        .rd_idx   (rd_idx),
        .rd_word  (rd_word),
        .hit_vec  (hit_vec),
        .valid_vec(valid_vec)
    );

    pmcam_first_set #(.N(DEPTH), .IW(IW)) u_match_pe (
        .vec  (hit_vec),
        .found(cmp_found),
        .idx  (cmp_idx)
    );

    pmcam_first_set #(.N(DEPTH), .IW(IW)) u_free_pe (
        .vec  (~valid_vec),
        .found(nf_found),
        .idx  (nf_idx)
    );

    // Two or more hits exist when clearing the lowest hit leaves a bit set.
    assign cmp_multi = |(hit_vec & (hit_vec - DEPTH'(1)));
    assign full      = !nf_found;

    // Decode write, clear and read-index controls for this cycle.
    always_comb begin
        wr_en  = 1'b0;
        clr_en = 1'b0;
        wr_idx = addr;
        rd_idx = (op_e == OP_RD_HPM) ? hit_idx_q : addr;
        if (cyc_go) begin
            unique case (op_e)
                OP_WR_AT:  wr_en = 1'b1;
                OP_WR_NF:  begin
                    wr_en  = nf_found;
                    wr_idx = nf_idx;
                end
                OP_WR_HPM: begin
                    wr_en  = hit_q;
                    wr_idx = hit_idx_q;
                end
                OP_INVAL:  clr_en = 1'b1;
                default:   ;
            endcase
        end
    end

    // Register the active address, read data and compare result per op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aa_q      <= '0;
            rdata_q   <= '0;
            hit_q     <= 1'b0;
            multi_q   <= 1'b0;
            hit_idx_q <= '0;
        end else if (cyc_go) begin
            unique case (op_e)
                OP_CMP: begin
                    hit_q     <= cmp_found;
                    multi_q   <= cmp_multi;
                    hit_idx_q <= cmp_idx;
                    aa_q      <= cmp_found ? AA_W'(cmp_idx) : AA_MISS;
                end
                OP_WR_AT, OP_INVAL: aa_q <= AA_W'(addr);
                OP_RD_AT: begin
                    aa_q    <= AA_W'(addr);
                    rdata_q <= rd_word;
                end
                OP_WR_NF:  aa_q <= nf_found ? AA_W'(nf_idx) : AA_MISS;
                OP_WR_HPM: aa_q <= hit_q ? AA_W'(hit_idx_q) : AA_MISS;
                OP_RD_HPM: begin
                    aa_q <= hit_q ? AA_W'(hit_idx_q) : AA_MISS;
                    if (hit_q) rdata_q <= rd_word;
                end
                default: ;
            endcase
        end
    end

    // Gate the active-address bus with its output enable.
    assign aa_bus     = aa_oe_n ? '0 : aa_q;
    assign aa_drive   = !aa_oe_n;
    assign rdata      = rdata_q;
    assign match_flag = hit_q;
    assign multi_flag = multi_q;
endmodule

// File: rtl/pmcam_chk.sv
// Port-level assertions for pmcam_top, attached through bind.
module pmcam_chk #(
    parameter int AA_W = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cyc_go,
    input logic [2:0]      op,
    input logic            aa_oe_n,
    input logic [AA_W-1:0] aa_bus,
    input logic            aa_drive,
    input logic            match_flag,
    input logic            multi_flag,
    input logic            full
);
    // R2
    multi_implies_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        multi_flag |-> match_flag);

    // R3
    cmp_miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_go && op == 3'd1 && !aa_oe_n) |=> (aa_oe_n || match_flag || aa_bus == '1));

    // R5
    nf_full_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_go && op == 3'd4 && full && !aa_oe_n) |=> (aa_oe_n || aa_bus == '1));

    // R8
    aa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cyc_go || op == 3'd0) && !aa_oe_n) |=> (aa_oe_n || $stable(aa_bus)));

    // R9
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aa_oe_n |-> (aa_bus == '0 && !aa_drive));

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_go || op != 3'd1) |=> ($stable(match_flag) && $stable(multi_flag)));
endmodule

bind pmcam_top pmcam_chk #(.AA_W(AA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_go    (cyc_go),
    .op        (op),
    .aa_oe_n   (aa_oe_n),
    .aa_bus    (aa_bus),
    .aa_drive  (aa_drive),
    .match_flag(match_flag),
    .multi_flag(multi_flag),
    .full      (full)
);

// File: tb/pmcam_top_tb.sv
`timescale 1ns/1ps
module pmcam_top_tb;
    localparam int DEPTH = 8;
    localparam int WIDTH = 64;
    localparam int AA_W  = 13;
    localparam int IW    = 3;
    localparam logic [AA_W-1:0] MISS = 13'h1FFF;

    localparam logic [63:0] VA = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] VB = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] VC = 64'h0000_0000_0000_3333;
    localparam logic [63:0] VD = 64'hDEAD_BEEF_0000_0001;
    localparam logic [63:0] VE = 64'h5555_AAAA_5555_AAAA;

    typedef struct packed {
        logic [2:0]      op;
        logic [IW-1:0]   adr;
        logic [63:0]     dat;
        logic            chk_rd;
        logic [63:0]     rd;
        logic [AA_W-1:0] aa;
        logic            m;
        logic            mm;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{3'd4, 3'd0, VA, 1'b0, 64'd0, 13'd0, 1'b0, 1'b0},  // R4 first free 0
        '{3'd4, 3'd0, VB, 1'b0, 64'd0, 13'd1, 1'b0, 1'b0},  // R4 next free 1
        '{3'd2, 3'd5, VA, 1'b0, 64'd0, 13'd5, 1'b0, 1'b0},  // R6 direct write
        '{3'd1, 3'd0, VA, 1'b0, 64'd0, 13'd0, 1'b1, 1'b1},  // R2 lowest of two
        '{3'd1, 3'd0, VB, 1'b0, 64'd0, 13'd1, 1'b1, 1'b0},  // R2 single
        '{3'd1, 3'd0, VC, 1'b0, 64'd0, MISS,  1'b0, 1'b0},  // R3 miss
        '{3'd4, 3'd0, VC, 1'b0, 64'd0, 13'd2, 1'b0, 1'b0},  // R4 skips used
        '{3'd3, 3'd5, 64'd0, 1'b1, VA, 13'd5, 1'b0, 1'b0},  // R6 read
        '{3'd1, 3'd0, VA, 1'b0, 64'd0, 13'd0, 1'b1, 1'b1},  // R2 again
        '{3'd6, 3'd3, VD, 1'b0, 64'd0, 13'd0, 1'b1, 1'b1},  // R7 write at match
        '{3'd5, 3'd3, 64'd0, 1'b1, VD, 13'd0, 1'b1, 1'b1},  // R7 read at match
        '{3'd7, 3'd0, 64'd0, 1'b0, 64'd0, 13'd0, 1'b1, 1'b1},  // R6 invalidate
        '{3'd4, 3'd0, VE, 1'b0, 64'd0, 13'd0, 1'b1, 1'b1},  // R4 reuse freed
        '{3'd1, 3'd0, VD, 1'b0, 64'd0, MISS,  1'b0, 1'b0},  // R3 overwritten
        '{3'd5, 3'd0, 64'd0, 1'b1, VD, MISS,  1'b0, 1'b0}   // R7 miss, rdata kept
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cyc_go;
    logic [2:0]       op;
    logic [IW-1:0]    addr;
    logic [WIDTH-1:0] din;
    logic             aa_oe_n;
    logic [AA_W-1:0]  aa_bus;
    logic             aa_drive;
    logic [WIDTH-1:0] rdata;
    logic             match_flag, multi_flag, full;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pmcam_top #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AA_W(AA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_go(cyc_go), .op(op), .addr(addr),
        .din(din), .aa_oe_n(aa_oe_n), .aa_bus(aa_bus), .aa_drive(aa_drive),
        .rdata(rdata), .match_flag(match_flag), .multi_flag(multi_flag),
        .full(full)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one strobed operation; outputs are valid at the following negedge.
    task automatic run_op(input logic [2:0] o, input logic [IW-1:0] a, input logic [63:0] d);
        @(negedge clk);
        cyc_go = 1'b1; op = o; addr = a; din = d;
        @(negedge clk);
        cyc_go = 1'b0; op = 3'd0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cyc_go = 1'b0; op = 3'd0; addr = '0; din = '0; aa_oe_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 aa", 64'(aa_bus), 64'd0);
        chk("R1 rdata", rdata, 64'd0);
        chk("R1 flags", {61'd0, match_flag, multi_flag, full}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_op(TBL[i].op, TBL[i].adr, TBL[i].dat);
            chk($sformatf("vec%0d aa", i), 64'(aa_bus), 64'(TBL[i].aa));
            chk($sformatf("vec%0d flags R10", i), {62'd0, match_flag, multi_flag},
                {62'd0, TBL[i].m, TBL[i].mm});
            if (TBL[i].chk_rd) chk($sformatf("vec%0d rdata", i), rdata, TBL[i].rd);
        end

        // R8: no strobe and op 0 leave aa and rdata alone
        @(negedge clk);
        op = 3'd1; din = VA;
        repeat (2) @(negedge clk);
        chk("R8 aa no strobe", 64'(aa_bus), 64'(MISS));
        chk("R10 flags no strobe", {62'd0, match_flag, multi_flag}, 64'd0);
        op = 3'd0;
        run_op(3'd0, 3'd6, VA);
        chk("R8 aa nop", 64'(aa_bus), 64'(MISS));
        chk("R8 rdata nop", rdata, VD);

        // R9: output enable off
        aa_oe_n = 1'b1;
        #1;
        chk("R9 bus off", {63'd0, aa_drive} | 64'(aa_bus), 64'd0);
        aa_oe_n = 1'b0;
        #1;
        chk("R9 bus on", {63'd0, aa_drive}, 64'd1);

        // R4/R5: fill slots 3,4,6,7 then overflow
        chk("R5 not full", {63'd0, full}, 64'd0);
        run_op(3'd4, 3'd0, 64'h10); chk("R4 fill 3", 64'(aa_bus), 64'd3);
        run_op(3'd4, 3'd0, 64'h11); chk("R4 fill 4", 64'(aa_bus), 64'd4);
        run_op(3'd4, 3'd0, 64'h12); chk("R4 fill 6", 64'(aa_bus), 64'd6);
        run_op(3'd4, 3'd0, 64'h13); chk("R4 fill 7", 64'(aa_bus), 64'd7);
        chk("R5 full", {63'd0, full}, 64'd1);
        run_op(3'd4, 3'd0, 64'h99);
        chk("R5 full miss aa", 64'(aa_bus), 64'(MISS));
        run_op(3'd1, 3'd0, 64'h99);
        chk("R5 no write on full", {63'd0, match_flag}, 64'd0);
        run_op(3'd1, 3'd0, 64'h13);
        chk("R2 last slot hit", 64'(aa_bus), 64'd7);
        run_op(3'd3, 3'd2, 64'd0);
        chk("R6 read slot 2", rdata, VC);

        // R3: invalidated entry no longer matches
        run_op(3'd7, 3'd7, 64'd0);
        run_op(3'd1, 3'd0, 64'h13);
        chk("R3 empty never hits", 64'(aa_bus), 64'(MISS));
        // R7: write at match after a miss writes nothing
        run_op(3'd6, 3'd0, 64'h77);
        chk("R7 miss aa", 64'(aa_bus), 64'(MISS));
        run_op(3'd1, 3'd0, 64'h77);
        chk("R7 no write on miss", {63'd0, match_flag}, 64'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule